// File: doc/BRIEF.md
# Handshaking Two-Way Intersection Light Controller

This block sequences the lights of a crossing of two conflicting roads with no turning phases. It steps through four light phases: main road green, main road yellow, cross road green and cross road yellow. A direction that shows green keeps it until two things are true. A vehicle must be reported waiting on the red road, and the green must have lasted at least a configured number of cycles. A yellow phase always runs for its own configured number of cycles and then hands over.

Each light step is negotiated with a remote site through an active-low request/acknowledge pair. The controller lowers its request and holds it low until the remote site lowers acknowledge. At that point the phase advances and the request is released. The controller then waits for acknowledge to return high before it starts timing the new phase. With every advance it also flips a level-style line, so each edge on that line moves a physical light panel one step. The vehicle and acknowledge inputs are asynchronous and are passed through two-flop synchronisers.

Top module: `xlc_top`

## Requirements
- R1: While `rst_n` is low, `phase_o` is 0 (main green, cross red), `real_tgl_n` is 0 and `sim_req_n` is 1.
- R2: `phase_o` advances only by one step in the order 0 (main green) → 1 (main yellow) → 2 (cross green) → 3 (cross yellow) → 0.
- R3: A green phase (code 0 or 2) issues a request only while `car_wait_n` is low (a vehicle waiting). The request comes at least `GREEN_CYC` cycles after acknowledge returned high. If that minimum has already passed, it comes within 6 cycles of `car_wait_n` falling.
- R4: While `car_wait_n` stays high, a green phase is never left and `sim_req_n` stays 1, however long the phase lasts.
- R5: A yellow phase (code 1 or 3) issues its request between `YEL_CYC` and `YEL_CYC`+6 cycles after acknowledge returned high, whatever the level of `car_wait_n`.
- R6: `sim_req_n` stays low until `ack_n` is seen low. It then rises in the same cycle that `phase_o` advances.
- R7: `real_tgl_n` changes level exactly once for each phase advance and at no other time.
- R8: While `ack_n` stays low after a step, no new request is made and `phase_o` does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| car_wait_n | input | 1 | Low when a vehicle waits on the red road (asynchronous) |
| ack_n | input | 1 | Low when the remote site acknowledges a light change (asynchronous) |
| sim_req_n | output | 1 | Low while a light change is requested from the remote site |
| real_tgl_n | output | 1 | Level flipped once per light step for the physical panel |
| phase_o | output | 2 | Current phase: 0 main green, 1 main yellow, 2 cross green, 3 cross yellow |

## Verification
The vehicle input is tried in three patterns. Held inactive for a long time, it shows that green is never abandoned. Raised after the minimum green has already elapsed, it shows the saturated timer gives an immediate request. Held active from the start of a green, it shows the minimum green is still enforced. Yellow phases are timed once with the vehicle input inactive and once with it active, which shows yellow ignores it. The acknowledge is held low for a long time and also withheld for a long time, which tells apart a controller that waits correctly on each handshake edge from one that advances early or re-requests.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  typedef enum logic [1:0] {
    PH_MAIN_GO   = 2'd0,
    PH_MAIN_SLOW = 2'd1,
    PH_CROSS_GO  = 2'd2,
    PH_CROSS_SLOW = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    HS_RUN  = 2'd0,
    HS_ASK  = 2'd1,
    HS_DROP = 2'd2
  } hs_e;

  function automatic phase_e phase_after(input phase_e p);
    case (p)
      PH_MAIN_GO:   phase_after = PH_MAIN_SLOW;
      PH_MAIN_SLOW: phase_after = PH_CROSS_GO;
      PH_CROSS_GO:  phase_after = PH_CROSS_SLOW;
      default:      phase_after = PH_MAIN_GO;
    endcase
  endfunction

  function automatic logic is_green(input phase_e p);
    is_green = (p == PH_MAIN_GO) || (p == PH_CROSS_GO);
  endfunction
endpackage

// File: rtl/xlc_sync.sv
module xlc_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/xlc_timer.sv
module xlc_timer #(
  parameter int GREEN_CYC = 20,
  parameter int YEL_CYC   = 6,
  parameter int CNT_W     = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic green_ok_o,
  output logic yel_ok_o
);
  localparam int LIM = (GREEN_CYC > YEL_CYC) ? GREEN_CYC : YEL_CYC;
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIM);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LIM_V) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign green_ok_o = (cnt_q >= CNT_W'(GREEN_CYC));
  assign yel_ok_o   = (cnt_q >= CNT_W'(YEL_CYC));
endmodule

// File: rtl/xlc_fsm.sv
module xlc_fsm
  import xlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   car_i,
  input  logic   ack_i,
  input  logic   green_ok_i,
  input  logic   yel_ok_i,
  output logic   run_o,
  output logic   req_n_o,
  output logic   tgl_n_o,
  output phase_e phase_o
);
  hs_e    hs_q, hs_d;
  phase_e ph_q, ph_d;
  logic   tgl_q, tgl_d;
  logic   req_q, req_d;
  logic   leave;

  always_comb begin
    hs_d  = hs_q;
    ph_d  = ph_q;
    tgl_d = tgl_q;
    leave = is_green(ph_q) ? (car_i && green_ok_i) : yel_ok_i;
    case (hs_q)
      HS_RUN:  if (leave) hs_d = HS_ASK;
      HS_ASK:  if (ack_i) begin
                 hs_d  = HS_DROP;
                 ph_d  = phase_after(ph_q);
                 tgl_d = ~tgl_q;
               end
      HS_DROP: if (!ack_i) hs_d = HS_RUN;
      default: hs_d = HS_RUN;
    endcase
    req_d = (hs_d != HS_ASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= HS_RUN;
      ph_q  <= PH_MAIN_GO;
      tgl_q <= 1'b0;
      req_q <= 1'b1;
    end else begin
      hs_q  <= hs_d;
      ph_q  <= ph_d;
      tgl_q <= tgl_d;
      req_q <= req_d;
    end
  end

  assign run_o   = (hs_q == HS_RUN);
  assign req_n_o = req_q;
  assign tgl_n_o = tgl_q;
  assign phase_o = ph_q;
endmodule

// File: rtl/xlc_top.sv
module xlc_top
  import xlc_pkg::*;
#(
  parameter int GREEN_CYC = 20,
  parameter int YEL_CYC   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       car_wait_n,
  input  logic       ack_n,
  output logic       sim_req_n,
  output logic       real_tgl_n,
  output logic [1:0] phase_o
);
  localparam int LIM   = (GREEN_CYC > YEL_CYC) ? GREEN_CYC : YEL_CYC;
  localparam int CNT_W = $clog2(LIM + 1);

  logic [1:0] raw_in, sync_in;
  logic       car_seen, ack_seen;
  logic       run, green_ok, yel_ok;
  phase_e     phase;

  assign raw_in = {car_wait_n, ack_n};

  xlc_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_in)
  );

  assign car_seen = ~sync_in[1];
  assign ack_seen = ~sync_in[0];

  xlc_timer #(.GREEN_CYC(GREEN_CYC), .YEL_CYC(YEL_CYC), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .green_ok_o(green_ok), .yel_ok_o(yel_ok)
  );

  xlc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .car_i(car_seen), .ack_i(ack_seen),
    .green_ok_i(green_ok), .yel_ok_i(yel_ok), .run_o(run),
    .req_n_o(sim_req_n), .tgl_n_o(real_tgl_n), .phase_o(phase)
  );

  assign phase_o = phase;
endmodule

// File: rtl/xlc_chk.sv
module xlc_chk #(
  parameter int GREEN_CYC = 20,
  parameter int YEL_CYC   = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sim_req_n,
  input logic       real_tgl_n,
  input logic [1:0] phase_o,
  input logic       car_seen,
  input logic       ack_seen
);
  localparam int LIM = (GREEN_CYC > YEL_CYC) ? GREEN_CYC : YEL_CYC;
  localparam int CW  = $clog2(LIM + 1);

  logic [1:0]    ph_prev;
  logic          tgl_prev;
  logic [CW-1:0] age;
  logic          stepped;
  logic          green_now;

  assign stepped   = (phase_o != ph_prev);
  assign green_now = (phase_o == 2'd0) || (phase_o == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_prev  <= 2'd0;
      tgl_prev <= 1'b0;
      age      <= '0;
    end else begin
      ph_prev  <= phase_o;
      tgl_prev <= real_tgl_n;
      if (stepped)                age <= '0;
      else if (age != CW'(LIM))   age <= age + 1'b1;
    end
  end

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepped |-> (phase_o == 2'(ph_prev + 2'd1)));

  // R7
  toggle_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepped |-> (real_tgl_n != tgl_prev));

  // R7
  toggle_only_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (real_tgl_n != tgl_prev) |-> stepped);

  // R6
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sim_req_n) |-> stepped);

  // R6
  step_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepped |-> $past(ack_seen));

  // R3
  green_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sim_req_n) && green_now) |-> (age >= CW'(GREEN_CYC)));

  // R3
  green_car_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sim_req_n) && green_now) |-> $past(car_seen));

  // R5
  yellow_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sim_req_n) && !green_now) |-> (age >= CW'(YEL_CYC)));
endmodule

bind xlc_top xlc_chk #(.GREEN_CYC(GREEN_CYC), .YEL_CYC(YEL_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sim_req_n(sim_req_n), .real_tgl_n(real_tgl_n),
  .phase_o(phase_o), .car_seen(car_seen), .ack_seen(ack_seen)
);

// File: tb/sim_xlc_top.sv
`timescale 1ns/1ps
module sim_xlc_top;
  localparam int G = 20;
  localparam int Y = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       car_wait_n;
  logic       ack_n;
  logic       sim_req_n;
  logic       real_tgl_n;
  logic [1:0] phase_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  xlc_top #(.GREEN_CYC(G), .YEL_CYC(Y)) u0 (
    .clk(clk), .rst_n(rst_n), .car_wait_n(car_wait_n), .ack_n(ack_n),
    .sim_req_n(sim_req_n), .real_tgl_n(real_tgl_n), .phase_o(phase_o)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_req(output int cyc, input int maxc);
    cyc = 0;
    while (sim_req_n && cyc < maxc) begin
      tick(1);
      cyc++;
    end
  endtask

  // grant a pending request, hold ack low for 'hold' cycles, then release
  task automatic answer(input int hold, input int exp_ph, input logic exp_tgl);
    int c;
    tick(2);
    ack_n = 1'b0;
    c = 0;
    while (!sim_req_n && c < 8) begin
      tick(1);
      c++;
    end
    check(sim_req_n == 1'b1, "R6 request released after ack", sim_req_n, 1);
    check(phase_o == 2'(exp_ph), "R2 phase after step", phase_o, exp_ph);
    check(real_tgl_n == exp_tgl, "R7 toggle after step", real_tgl_n, exp_tgl);
    tick(hold);
    check(sim_req_n == 1'b1, "R8 no request while ack low", sim_req_n, 1);
    check(phase_o == 2'(exp_ph), "R8 phase still while ack low", phase_o, exp_ph);
    ack_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; car_wait_n = 1'b1; ack_n = 1'b1;
    tick(3);
    check(phase_o == 2'd0, "R1 reset phase", phase_o, 0);
    check(real_tgl_n == 1'b0, "R1 reset toggle", real_tgl_n, 0);
    check(sim_req_n == 1'b1, "R1 reset request", sim_req_n, 1);
    rst_n = 1'b1;
  endtask

  task automatic t_no_car();
    int c;
    wait_req(c, 120);
    check(sim_req_n == 1'b1, "R4 no request without car", sim_req_n, 1);
    check(phase_o == 2'd0, "R4 green kept", phase_o, 0);
  endtask

  task automatic t_late_car();
    int c;
    car_wait_n = 1'b0;
    wait_req(c, 40);
    check(c >= 2 && c <= 6, "R3 saturated timer gives quick request", c, 4);
    answer(30, 1, 1'b1);
  endtask

  task automatic t_yellow(input logic car_lvl, input int exp_ph, input logic exp_tgl);
    int c;
    car_wait_n = car_lvl;
    wait_req(c, 60);
    check(c >= Y && c <= Y + 6, "R5 yellow length", c, Y);
    answer(0, exp_ph, exp_tgl);
  endtask

  task automatic t_green_min(input int exp_ph, input logic exp_tgl);
    int c;
    car_wait_n = 1'b0;
    wait_req(c, 80);
    check(c >= G && c <= G + 6, "R3 minimum green", c, G);
    answer(0, exp_ph, exp_tgl);
  endtask

  task automatic t_withhold_ack();
    int c;
    car_wait_n = 1'b0;
    wait_req(c, 80);
    tick(40);
    check(sim_req_n == 1'b0, "R6 request held without ack", sim_req_n, 0);
    check(phase_o == 2'd0, "R6 no step without ack", phase_o, 0);
    answer(0, 1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_no_car();                  // phase 0, no car
    t_late_car();                // -> 1
    t_yellow(1'b1, 2, 1'b0);     // -> 2, car inactive
    t_green_min(3, 1'b1);        // -> 3
    t_yellow(1'b0, 0, 1'b0);     // -> 0 wrap, car active
    t_withhold_ack();            // -> 1
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(20000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule